// File: doc/BRIEF.md
# Decoupled Memory-Side Vector Register Manager

This block sits between a vector coprocessor's memory system and the rest of its datapath. It owns a small pool of local vector registers and splits each memory operation into two independently issued steps. A load first fills a free local register from memory. A separate, later move-out streams that register to the rest of the machine. A store first moves a vector into a local register. A separate store command then writes that register to memory. One store variant frees the register as soon as its writes are issued. The rest of the machine therefore never waits on memory latency directly.

Two sequencers run in parallel. The memory sequencer handles loads and stores through a request/response memory interface with unit-stride addressing. The transfer sequencer handles move-in and move-out streams. Each local register is tracked as free, filling, full or draining. Every command gets a one-cycle-later reply that either accepts it (with the register used) or refuses it as busy.

Top module: `vdecouple_mgr`

## Requirements
- R1: After reset every local register is free; `rsp_valid`, `mem_req_valid` and `xo_valid` are 0, and the first load is given register 0.
- R2: A command with `cmd_op`=1 (load) and a free register allocates the lowest-numbered free register. One cycle after the command, `rsp_valid`=1, `rsp_busy`=0 and `rsp_reg` gives the register. It then issues VLEN reads (`mem_req_we`=0) at `cmd_addr`+0 .. `cmd_addr`+VLEN-1, in element order.
- R3: A load issued when no register is free is refused with `rsp_busy`=1 and issues no memory request.
- R4: `cmd_op`=2 (move-out) of register `cmd_reg` streams its VLEN elements, element 0 first, one per cycle on `xo_data` with `xo_valid`=1. `xo_last`=1 marks only the final element. Afterwards the register is free again and is the one a following load receives.
- R5: A move-out of a register that is still filling is accepted. Its first `xo_valid` appears only after the last memory response of that fill, and the data are the loaded words.
- R6: `cmd_op`=3 (move-in) allocates the lowest free register and reports it in `rsp_reg`. It stores the next VLEN words presented with `xi_valid`=1 as elements 0..VLEN-1, after which the register is full.
- R7: `cmd_op`=4 (store) of a full register issues VLEN writes (`mem_req_we`=1) of elements 0..VLEN-1 to `cmd_addr`+i. The register stays full, so a further store of it is accepted.
- R8: `cmd_op`=5 (store-and-free) issues the same writes as R7 and then returns the register to free, so the next load receives it.
- R9: A command is refused with `rsp_busy`=1 and no effect on any register or port in these cases: its sequencer is busy; it is a move-out of a register that is neither filling nor full; or it is a store of a register that is not full. Opcodes 0, 6 and 7 are also refused.
- R10: While `mem_req_valid`=1 and `mem_req_ready`=0, the request stays valid, and its address and direction do not change in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Operation code (see R2–R9) |
| cmd_reg | input | IW | Local register operand for move-out and store |
| cmd_addr | input | AW | Base memory address for load and store |
| rsp_valid | output | 1 | Reply to the previous cycle's command |
| rsp_busy | output | 1 | Command refused |
| rsp_reg | output | IW | Register allocated or addressed |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | AW | Request address |
| mem_req_wdata | output | DW | Write data |
| mem_rsp_valid | input | 1 | Read data returned (in request order) |
| mem_rsp_rdata | input | DW | Read data |
| xi_valid | input | 1 | Move-in element present |
| xi_data | input | DW | Move-in element |
| xo_valid | output | 1 | Move-out element present |
| xo_data | output | DW | Move-out element |
| xo_last | output | 1 | Final element of a move-out |

## Verification
The hardest situation to reach from the ports is a move-out that lands on a register whose fill is still in flight. The move-out must park, wait for the last read response, and only then start streaming. The bench issues the move-out in the cycle right after the load. Its memory model withdraws ready one cycle in three and returns data two cycles late, so the fill spans many cycles. The bench then compares the cycle of the first streamed element with the cycle of the last response. Refusals are provoked by filling the whole pool, by issuing back-to-back loads, and by storing or moving out a register that has just been freed. Each refusal is followed by checks that no memory request or stream appeared.

// File: rtl/vdm_pkg.sv
package vdm_pkg;
  typedef enum logic [1:0] {
    RS_FREE     = 2'd0,
    RS_FILLING  = 2'd1,
    RS_FULL     = 2'd2,
    RS_DRAINING = 2'd3
  } rstate_t;

  typedef enum logic [2:0] {
    OP_NOP        = 3'd0,
    OP_LOAD       = 3'd1,
    OP_MOVE_OUT   = 3'd2,
    OP_MOVE_IN    = 3'd3,
    OP_STORE      = 3'd4,
    OP_STORE_FREE = 3'd5
  } op_t;
endpackage

// File: rtl/vdm_regstate.sv
module vdm_regstate
  import vdm_pkg::*;
#(
  parameter int NREG = 4,
  localparam int IW = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          alloc_en,
  input  logic [IW-1:0] alloc_idx,
  input  logic          drain_en,
  input  logic [IW-1:0] drain_idx,
  input  logic          take_en,
  input  logic [IW-1:0] take_idx,
  input  logic          ld_done_en,
  input  logic [IW-1:0] ld_done_idx,
  input  logic          in_done_en,
  input  logic [IW-1:0] in_done_idx,
  input  logic          out_done_en,
  input  logic [IW-1:0] out_done_idx,
  input  logic          st_done_en,
  input  logic [IW-1:0] st_done_idx,
  input  logic          st_done_free,
  output rstate_t       st_o [NREG],
  output logic          any_free,
  output logic [IW-1:0] free_idx
);
  rstate_t st_q [NREG];

  always_ff @(posedge clk) begin
    for (int i = 0; i < NREG; i++) begin
      if (rst) st_q[i] <= RS_FREE;
      else begin
        if (alloc_en    && alloc_idx    == IW'(i)) st_q[i] <= RS_FILLING;
        if (drain_en    && drain_idx    == IW'(i)) st_q[i] <= RS_DRAINING;
        if (take_en     && take_idx     == IW'(i)) st_q[i] <= RS_DRAINING;
        if (ld_done_en  && ld_done_idx  == IW'(i)) st_q[i] <= RS_FULL;
        if (in_done_en  && in_done_idx  == IW'(i)) st_q[i] <= RS_FULL;
        if (out_done_en && out_done_idx == IW'(i)) st_q[i] <= RS_FREE;
        if (st_done_en  && st_done_idx  == IW'(i))
          st_q[i] <= st_done_free ? RS_FREE : RS_FULL;
      end
    end
  end

  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (st_q[i] == RS_FREE) begin
        any_free = 1'b1;
        free_idx = IW'(i);
      end
    end
  end

  always_comb for (int i = 0; i < NREG; i++) st_o[i] = st_q[i];

  p_alloc_free_r2: assert property (@(posedge clk) disable iff (rst)
    alloc_en |-> st_q[alloc_idx] == RS_FREE);
  p_store_full_r7: assert property (@(posedge clk) disable iff (rst)
    drain_en |-> st_q[drain_idx] == RS_FULL);
  p_take_full_r5: assert property (@(posedge clk) disable iff (rst)
    take_en |-> st_q[take_idx] == RS_FULL);
  p_fill_end_r2: assert property (@(posedge clk) disable iff (rst)
    ld_done_en |-> st_q[ld_done_idx] == RS_FILLING);
endmodule

// File: rtl/vdm_mem_seq.sv
module vdm_mem_seq #(
  parameter int NREG = 4,
  parameter int VLEN = 4,
  parameter int DW   = 16,
  parameter int AW   = 10,
  localparam int IW = $clog2(NREG),
  localparam int CW = $clog2(VLEN)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_ld,
  input  logic          start_st,
  input  logic          start_free,
  input  logic [IW-1:0] start_idx,
  input  logic [AW-1:0] start_addr,
  output logic          busy,
  output logic [IW-1:0] idx_o,
  output logic [CW-1:0] iel_o,
  input  logic [DW-1:0] rd_data,
  output logic          wr_en,
  output logic [CW-1:0] wel_o,
  output logic          ld_done,
  output logic          st_done,
  output logic          st_free,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_we,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  input  logic          mem_rsp_valid
);
  localparam logic [CW-1:0] LAST = CW'(VLEN - 1);

  logic          busy_q, is_st_q, free_q, iss_q;
  logic [IW-1:0] idx_q;
  logic [AW-1:0] base_q;
  logic [CW-1:0] icnt_q, rcnt_q;
  logic          acc;

  assign acc     = iss_q && mem_req_ready;
  assign wr_en   = busy_q && !is_st_q && mem_rsp_valid;
  assign ld_done = wr_en && rcnt_q == LAST;
  assign st_done = acc && is_st_q && icnt_q == LAST;
  assign st_free = free_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0; is_st_q <= 1'b0; free_q <= 1'b0; iss_q <= 1'b0;
      idx_q <= '0; base_q <= '0; icnt_q <= '0; rcnt_q <= '0;
    end else if (start_ld || start_st) begin
      busy_q  <= 1'b1;
      iss_q   <= 1'b1;
      is_st_q <= start_st;
      free_q  <= start_free;
      idx_q   <= start_idx;
      base_q  <= start_addr;
      icnt_q  <= '0;
      rcnt_q  <= '0;
    end else begin
      if (acc) begin
        if (icnt_q == LAST) begin
          iss_q <= 1'b0;
          if (is_st_q) busy_q <= 1'b0;
        end else icnt_q <= icnt_q + 1'b1;
      end
      if (wr_en) begin
        rcnt_q <= rcnt_q + 1'b1;
        if (rcnt_q == LAST) busy_q <= 1'b0;
      end
    end
  end

  assign busy          = busy_q;
  assign idx_o         = idx_q;
  assign iel_o         = icnt_q;
  assign wel_o         = rcnt_q;
  assign mem_req_valid = iss_q;
  assign mem_req_we    = is_st_q;
  assign mem_req_addr  = base_q + AW'(icnt_q);
  assign mem_req_wdata = rd_data;

  p_req_hold_r10: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=>
      mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we));
  p_rsp_expected_r2: assert property (@(posedge clk) disable iff (rst)
    mem_rsp_valid |-> busy_q && !is_st_q);
  p_start_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (start_ld || start_st) |-> !busy_q);
endmodule

// File: rtl/vdm_xfer_seq.sv
module vdm_xfer_seq #(
  parameter int NREG = 4,
  parameter int VLEN = 4,
  parameter int DW   = 16,
  localparam int IW = $clog2(NREG),
  localparam int CW = $clog2(VLEN)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_out,
  input  logic          start_in,
  input  logic [IW-1:0] start_idx,
  input  logic          cur_full,
  output logic          busy,
  output logic [IW-1:0] idx_o,
  output logic [CW-1:0] el_o,
  input  logic [DW-1:0] rd_data,
  output logic          take_en,
  output logic          out_done,
  output logic          in_done,
  output logic          wr_en,
  input  logic          xi_valid,
  output logic          xo_valid,
  output logic [DW-1:0] xo_data,
  output logic          xo_last
);
  localparam logic [CW-1:0] LAST = CW'(VLEN - 1);

  typedef enum logic [1:0] {X_IDLE, X_WAIT, X_SEND, X_RECV} xst_t;
  xst_t          xs_q;
  logic [IW-1:0] idx_q;
  logic [CW-1:0] cnt_q;

  assign take_en  = xs_q == X_WAIT && cur_full;
  assign out_done = xs_q == X_SEND && cnt_q == LAST;
  assign wr_en    = xs_q == X_RECV && xi_valid;
  assign in_done  = wr_en && cnt_q == LAST;

  always_ff @(posedge clk) begin
    if (rst) begin
      xs_q <= X_IDLE; idx_q <= '0; cnt_q <= '0;
      xo_valid <= 1'b0; xo_data <= '0; xo_last <= 1'b0;
    end else begin
      xo_valid <= 1'b0;
      xo_last  <= 1'b0;
      case (xs_q)
        X_IDLE: begin
          cnt_q <= '0;
          idx_q <= start_idx;
          if (start_out) xs_q <= X_WAIT;
          else if (start_in) xs_q <= X_RECV;
        end
        X_WAIT: if (cur_full) xs_q <= X_SEND;
        X_SEND: begin
          xo_valid <= 1'b1;
          xo_data  <= rd_data;
          xo_last  <= cnt_q == LAST;
          if (cnt_q == LAST) xs_q <= X_IDLE;
          else cnt_q <= cnt_q + 1'b1;
        end
        X_RECV: if (xi_valid) begin
          if (cnt_q == LAST) xs_q <= X_IDLE;
          else cnt_q <= cnt_q + 1'b1;
        end
        default: xs_q <= X_IDLE;
      endcase
    end
  end

  assign busy  = xs_q != X_IDLE;
  assign idx_o = idx_q;
  assign el_o  = cnt_q;

  p_last_ends_r4: assert property (@(posedge clk) disable iff (rst)
    xo_valid && xo_last |=> !xo_valid);
  p_start_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (start_out || start_in) |-> !busy);
endmodule

// File: rtl/vdecouple_mgr.sv
module vdecouple_mgr
  import vdm_pkg::*;
#(
  parameter int NREG = 4,
  parameter int VLEN = 4,
  parameter int DW   = 16,
  parameter int AW   = 10,
  localparam int IW = $clog2(NREG),
  localparam int CW = $clog2(VLEN)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic [IW-1:0] cmd_reg,
  input  logic [AW-1:0] cmd_addr,
  output logic          rsp_valid,
  output logic          rsp_busy,
  output logic [IW-1:0] rsp_reg,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_we,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_rdata,
  input  logic          xi_valid,
  input  logic [DW-1:0] xi_data,
  output logic          xo_valid,
  output logic [DW-1:0] xo_data,
  output logic          xo_last
);
  localparam int DEPTH = NREG * VLEN;

  logic [DW-1:0] ram [DEPTH];

  rstate_t       st [NREG];
  logic          any_free;
  logic [IW-1:0] free_idx;

  logic          m_busy, m_wr, m_ld_done, m_st_done, m_st_free;
  logic [IW-1:0] m_idx;
  logic [CW-1:0] m_iel, m_wel;
  logic [DW-1:0] m_rd;

  logic          x_busy, x_take, x_out_done, x_in_done, x_wr;
  logic [IW-1:0] x_idx;
  logic [CW-1:0] x_el;
  logic [DW-1:0] x_rd;

  logic ok, is_alloc;
  logic go_ld, go_st, go_out, go_in;
  rstate_t sel_st;

  assign sel_st = st[cmd_reg];

  always_comb begin
    ok       = 1'b0;
    is_alloc = 1'b0;
    case (cmd_op)
      OP_LOAD: begin
        ok = !m_busy && any_free; is_alloc = 1'b1;
      end
      OP_MOVE_IN: begin
        ok = !x_busy && any_free; is_alloc = 1'b1;
      end
      OP_MOVE_OUT:
        ok = !x_busy && (sel_st == RS_FILLING || sel_st == RS_FULL);
      OP_STORE, OP_STORE_FREE:
        ok = !m_busy && sel_st == RS_FULL && !(x_busy && x_idx == cmd_reg);
      default: ok = 1'b0;
    endcase
  end

  assign go_ld  = cmd_valid && ok && cmd_op == OP_LOAD;
  assign go_in  = cmd_valid && ok && cmd_op == OP_MOVE_IN;
  assign go_out = cmd_valid && ok && cmd_op == OP_MOVE_OUT;
  assign go_st  = cmd_valid && ok && (cmd_op == OP_STORE || cmd_op == OP_STORE_FREE);

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_busy  <= 1'b0;
      rsp_reg   <= '0;
    end else begin
      rsp_valid <= cmd_valid;
      rsp_busy  <= cmd_valid && !ok;
      rsp_reg   <= is_alloc ? free_idx : cmd_reg;
    end
  end

  // local register storage: one write per sequencer, one read per sequencer
  always_ff @(posedge clk) begin
    if (m_wr) ram[{m_idx, m_wel}] <= mem_rsp_rdata;
    if (x_wr) ram[{x_idx, x_el}]  <= xi_data;
  end
  assign m_rd = ram[{m_idx, m_iel}];
  assign x_rd = ram[{x_idx, x_el}];

  vdm_regstate #(.NREG(NREG)) u_state (
    .clk, .rst,
    .alloc_en    (go_ld || go_in),
    .alloc_idx   (free_idx),
    .drain_en    (go_st),
    .drain_idx   (cmd_reg),
    .take_en     (x_take),
    .take_idx    (x_idx),
    .ld_done_en  (m_ld_done),
    .ld_done_idx (m_idx),
    .in_done_en  (x_in_done),
    .in_done_idx (x_idx),
    .out_done_en (x_out_done),
    .out_done_idx(x_idx),
    .st_done_en  (m_st_done),
    .st_done_idx (m_idx),
    .st_done_free(m_st_free),
    .st_o        (st),
    .any_free    (any_free),
    .free_idx    (free_idx)
  );

  vdm_mem_seq #(.NREG(NREG), .VLEN(VLEN), .DW(DW), .AW(AW)) u_mem (
    .clk, .rst,
    .start_ld     (go_ld),
    .start_st     (go_st),
    .start_free   (cmd_op == OP_STORE_FREE),
    .start_idx    (go_ld ? free_idx : cmd_reg),
    .start_addr   (cmd_addr),
    .busy         (m_busy),
    .idx_o        (m_idx),
    .iel_o        (m_iel),
    .rd_data      (m_rd),
    .wr_en        (m_wr),
    .wel_o        (m_wel),
    .ld_done      (m_ld_done),
    .st_done      (m_st_done),
    .st_free      (m_st_free),
    .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_req_we   (mem_req_we),
    .mem_req_addr (mem_req_addr),
    .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid)
  );

  vdm_xfer_seq #(.NREG(NREG), .VLEN(VLEN), .DW(DW)) u_xfer (
    .clk, .rst,
    .start_out(go_out),
    .start_in (go_in),
    .start_idx(go_in ? free_idx : cmd_reg),
    .cur_full (st[x_idx] == RS_FULL),
    .busy     (x_busy),
    .idx_o    (x_idx),
    .el_o     (x_el),
    .rd_data  (x_rd),
    .take_en  (x_take),
    .out_done (x_out_done),
    .in_done  (x_in_done),
    .wr_en    (x_wr),
    .xi_valid (xi_valid),
    .xo_valid (xo_valid),
    .xo_data  (xo_data),
    .xo_last  (xo_last)
  );

  p_refuse_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_op == OP_LOAD && !any_free && !mem_req_valid |=> !mem_req_valid);
  p_no_overlap_r9: assert property (@(posedge clk) disable iff (rst)
    !(mem_req_valid && mem_req_we && x_busy && x_idx == m_idx && xo_valid));
endmodule

// File: tb/vdecouple_mgr_bench.sv
module vdecouple_mgr_bench;
  localparam int NREG = 4, VLEN = 4, DW = 16, AW = 10, IW = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;
  logic rst;

  logic          cmd_valid;
  logic [2:0]    cmd_op;
  logic [IW-1:0] cmd_reg;
  logic [AW-1:0] cmd_addr;
  logic          rsp_valid, rsp_busy;
  logic [IW-1:0] rsp_reg;
  logic          mem_req_valid, mem_req_ready, mem_req_we;
  logic [AW-1:0] mem_req_addr;
  logic [DW-1:0] mem_req_wdata;
  logic          mem_rsp_valid;
  logic [DW-1:0] mem_rsp_rdata;
  logic          xi_valid;
  logic [DW-1:0] xi_data;
  logic          xo_valid, xo_last;
  logic [DW-1:0] xo_data;

  vdecouple_mgr #(.NREG(NREG), .VLEN(VLEN), .DW(DW), .AW(AW)) u_vdecouple_mgr (.*);

  function automatic logic [DW-1:0] mword(input logic [AW-1:0] a);
    return DW'(int'(a) * 3 + 7);
  endfunction

  // memory model: ready low one cycle in three, read data two cycles late
  int mcyc;
  logic rv1;
  logic [DW-1:0] rd1;
  always @(posedge clk) begin
    if (rst) begin
      mcyc <= 0; mem_req_ready <= 1'b0; rv1 <= 1'b0; rd1 <= '0;
      mem_rsp_valid <= 1'b0; mem_rsp_rdata <= '0;
    end else begin
      mcyc <= mcyc + 1;
      mem_req_ready <= (mcyc % 3) != 1;
      rv1 <= mem_req_valid && mem_req_ready && !mem_req_we;
      rd1 <= mword(mem_req_addr);
      mem_rsp_valid <= rv1;
      mem_rsp_rdata <= rd1;
    end
  end

  // negedge monitor: logs accepted requests, streamed elements, R10 holds
  logic [AW-1:0] la [256];
  logic          lw [256];
  logic [DW-1:0] ld [256];
  int            ln = 0;
  logic [DW-1:0] xd [256];
  logic          xl [256];
  int            xc [256];
  int            xn = 0;
  int            ncyc = 0, last_rsp = -1;
  int            r10_n = 0, r10_bad = 0;
  logic          pstall = 1'b0;
  logic [AW-1:0] paddr;
  logic          pwe;
  always @(negedge clk) begin
    ncyc = ncyc + 1;
    if (!rst) begin
      if (pstall) begin
        r10_n = r10_n + 1;
        if (!(mem_req_valid && mem_req_addr == paddr && mem_req_we == pwe)) r10_bad = r10_bad + 1;
      end
      pstall = mem_req_valid && !mem_req_ready;
      paddr = mem_req_addr;
      pwe = mem_req_we;
      if (mem_req_valid && mem_req_ready && ln < 256) begin
        la[ln] = mem_req_addr; lw[ln] = mem_req_we; ld[ln] = mem_req_wdata; ln = ln + 1;
      end
      if (mem_rsp_valid) last_rsp = ncyc;
      if (xo_valid && xn < 256) begin
        xd[xn] = xo_data; xl[xn] = xo_last; xc[xn] = ncyc; xn = xn + 1;
      end
    end
  end

  int n_chk = 0, n_bad = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_cmd(input logic [2:0] op, input logic [IW-1:0] r, input logic [AW-1:0] a,
                        output logic busy, output logic [IW-1:0] rr);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_reg = r; cmd_addr = a;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd0;
    busy = rsp_busy; rr = rsp_reg;
    chk(rsp_valid == 1'b1, "rsp_valid", int'(rsp_valid), 1);
  endtask

  task automatic settle();
    repeat (24) @(negedge clk);
  endtask

  task automatic chk_reads(input int base, input logic [AW-1:0] a, input string tag);
    chk(ln - base == VLEN, {tag, " read count"}, ln - base, VLEN);
    for (int i = 0; i < VLEN; i++)
      chk(la[base+i] == a + AW'(i) && lw[base+i] == 1'b0, {tag, " read addr"},
          int'(la[base+i]), int'(a) + i);
  endtask

  task automatic chk_stream(input int base, input logic [AW-1:0] a, input string tag);
    chk(xn - base == VLEN, {tag, " stream count"}, xn - base, VLEN);
    for (int i = 0; i < VLEN; i++) begin
      chk(xd[base+i] == mword(a + AW'(i)), {tag, " stream data"}, int'(xd[base+i]), int'(mword(a + AW'(i))));
      chk(xl[base+i] == (i == VLEN - 1), {tag, " xo_last"}, int'(xl[base+i]), int'(i == VLEN - 1));
    end
  endtask

  // R1
  task automatic t_reset();
    chk(rsp_valid == 0 && mem_req_valid == 0 && xo_valid == 0, "R1 idle outputs",
        int'({rsp_valid, mem_req_valid, xo_valid}), 0);
  endtask

  // R2, R4, R5: load then immediate move-out of the filling register
  task automatic t_load_chain();
    logic b; logic [IW-1:0] r; int lb, xb;
    lb = ln; xb = xn;
    do_cmd(3'd1, '0, 10'h010, b, r);
    chk(!b && r == 0, "R1 R2 first load gets reg0", int'({b, r}), 0);
    do_cmd(3'd2, 2'd0, '0, b, r);
    chk(!b, "R5 move-out of filling reg accepted", int'(b), 0);
    settle();
    chk_reads(lb, 10'h010, "R2");
    chk_stream(xb, 10'h010, "R4 R5");
    chk(xn > xb && xc[xb] > last_rsp, "R5 stream after last response", xc[xb], last_rsp + 1);
  endtask

  // R3, R9, R4 freeing
  task automatic t_pool();
    logic b; logic [IW-1:0] r; int lb, xb;
    do_cmd(3'd1, '0, 10'h020, b, r);
    chk(!b && r == 0, "R4 freed reg0 reused", int'(r), 0);
    do_cmd(3'd1, '0, 10'h040, b, r);
    chk(b, "R9 load while memory sequencer busy refused", int'(b), 1);
    settle();
    do_cmd(3'd1, '0, 10'h040, b, r); settle();
    chk(!b && r == 1, "R2 lowest free reg1", int'(r), 1);
    do_cmd(3'd1, '0, 10'h050, b, r); settle();
    do_cmd(3'd1, '0, 10'h060, b, r); settle();
    chk(!b && r == 3, "R2 reg3", int'(r), 3);
    lb = ln;
    do_cmd(3'd1, '0, 10'h070, b, r); settle();
    chk(b, "R3 load with pool full refused", int'(b), 1);
    chk(ln == lb, "R3 no request issued", ln - lb, 0);
    xb = xn;
    do_cmd(3'd2, 2'd2, '0, b, r); settle();
    chk(!b, "R4 move-out reg2 accepted", int'(b), 0);
    chk_stream(xb, 10'h050, "R4");
    lb = ln;
    do_cmd(3'd1, '0, 10'h070, b, r); settle();
    chk(!b && r == 2, "R4 reg2 free after move-out", int'(r), 2);
    chk_reads(lb, 10'h070, "R2 refill");
  endtask

  // R6, R7, R8, R9
  task automatic t_store();
    logic b; logic [IW-1:0] r; int lb, xb;
    do_cmd(3'd2, 2'd1, '0, b, r); settle();
    do_cmd(3'd3, '0, '0, b, r);
    chk(!b && r == 1, "R6 move-in allocates reg1", int'({b, r}), 1);
    for (int i = 0; i < VLEN; i++) begin
      xi_valid = 1'b1; xi_data = DW'(16'hA000 + i);
      @(negedge clk);
      xi_valid = 1'b0;
      if (i == 1) @(negedge clk);
    end
    settle();
    lb = ln;
    do_cmd(3'd4, 2'd1, 10'h200, b, r); settle();
    chk(!b, "R6 R7 store of moved-in reg accepted", int'(b), 0);
    chk(ln - lb == VLEN, "R7 write count", ln - lb, VLEN);
    for (int i = 0; i < VLEN; i++)
      chk(lw[lb+i] && la[lb+i] == 10'h200 + AW'(i) && ld[lb+i] == DW'(16'hA000 + i),
          "R6 R7 write", int'(ld[lb+i]), 16'hA000 + i);
    do_cmd(3'd4, 2'd1, 10'h210, b, r); settle();
    chk(!b, "R7 reg stays full after store", int'(b), 0);
    lb = ln;
    do_cmd(3'd5, 2'd1, 10'h220, b, r); settle();
    chk(!b && ln - lb == VLEN, "R8 store-and-free writes", ln - lb, VLEN);
    chk(la[lb+VLEN-1] == 10'h223 && ld[lb+VLEN-1] == DW'(16'hA003), "R8 last write",
        int'(ld[lb+VLEN-1]), 16'hA003);
    lb = ln; xb = xn;
    do_cmd(3'd4, 2'd1, 10'h230, b, r); settle();
    chk(b && ln == lb, "R9 store of free reg refused", int'(b), 1);
    do_cmd(3'd2, 2'd1, '0, b, r); settle();
    chk(b && xn == xb, "R9 move-out of free reg refused", int'(b), 1);
    do_cmd(3'd6, 2'd0, '0, b, r);
    chk(b, "R9 unused opcode refused", int'(b), 1);
    do_cmd(3'd1, '0, 10'h080, b, r); settle();
    chk(!b && r == 1, "R8 freed reg1 reallocated", int'(r), 1);
  endtask

  initial begin
    cmd_valid = 1'b0; cmd_op = '0; cmd_reg = '0; cmd_addr = '0;
    xi_valid = 1'b0; xi_data = '0;
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_load_chain();
    t_pool();
    t_store();
    chk(r10_n > 0 && r10_bad == 0, "R10 stalled request held", r10_bad, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule